// File: doc/BRIEF.md
# Banked 24-bit CPU register file

This block stores the register state of an 8-bit processor core that runs with 24-bit addresses. It holds the accumulator and flag byte, three 24-bit general pairs (BC, DE, HL), two 24-bit index registers (IX, IY), the interrupt-vector byte I, the refresh byte R, the memory base byte MBASE, a 24-bit program counter, a 24-bit and a 16-bit stack pointer, and four single-bit mode flags. A and F have a second copy, as do the three general pairs including their top bytes. Two exchange inputs switch between the copies.

One write port and one combinational read port serve the whole file. Both are addressed by a 5-bit register code. Some codes name one byte and others name a whole 24-bit register. The top byte of any 24-bit register can be reached only through a 24-bit code. Two small enumerated state machines track which copy is live: one for A/F and one for the general pairs. The EX AF input moves the A/F machine between its MAIN and ALT states. The EXX input does the same for the pair machine. Reset returns both machines to MAIN.

Top module: `regfile24`

## Requirements
- R1: While `rst_n` is low and after it rises, I, R, MBASE, IX, IY, PC, SPL (24-bit stack pointer) and SPS (16-bit stack pointer) read as zero, and the `adl`, `madl`, `ief1` and `ief2` outputs are 0.
- R2: The register codes are: A=0, F=1, B=2, C=3, D=4, E=5, H=6, L=7, IXH=8, IXL=9, IYH=10, IYL=11, I=12, R=13, MBASE=14, BC=16, DE=17, HL=18, IX=19, IY=20, PC=21, SPL=22, SPS=23. A byte code reads its byte zero-extended on `rd_data`. A 24-bit code reads and writes all 24 bits. SPS takes `wr_data[15:0]` and reads zero-extended.
- R3: A cycle with `ex_af` high moves the A/F machine MAIN to ALT or ALT to MAIN at that clock edge. Reads then return the other copy. A write to A or F in the same cycle lands in the copy that was live before the edge.
- R4: A cycle with `exx` high swaps the live copy of BC, DE and HL, with all 24 bits, at that clock edge. A same-cycle write to a pair lands in the copy that was live before the edge.
- R5: A byte write to B, C, D, E, H, L, IXH, IXL, IYH or IYL changes only that byte. The top byte and the other byte of the register keep their values.
- R6: A write to MBASE takes effect only if `adl` was 1 before the clock edge. Otherwise MBASE keeps its value. A flag write in the same cycle does not change the outcome.
- R7: When a register is written and read in the same cycle, `rd_data` shows the old value in that cycle and the new value from the next cycle on.
- R8: A cycle with `flag_we` high loads `flag_val` into the flag chosen by `flag_sel`: 0=ADL, 1=MADL, 2=IEF1, 3=IEF2. The other flags keep their values.
- R9: Codes 15 and 24 to 31 read as zero. Writes to these codes change no register.
- R10: Reset does not load A, F, B, C, D, E, H, L or their top bytes, in either copy. A value written before reset reads back unchanged from the MAIN copy after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Code of the register to write |
| wr_data | input | 24 | Write data; byte codes use bits 7:0 |
| ex_af | input | 1 | Swap the live A/F copy |
| exx | input | 1 | Swap the live BC/DE/HL copy |
| flag_we | input | 1 | Flag write strobe |
| flag_sel | input | 2 | Flag to write |
| flag_val | input | 1 | New flag value |
| rd_sel | input | 5 | Code of the register to read |
| rd_data | output | 24 | Combinational read data |
| adl | output | 1 | 24-bit address mode flag |
| madl | output | 1 | Mixed-mode flag |
| ief1 | output | 1 | Interrupt enable flag 1 |
| ief2 | output | 1 | Interrupt enable flag 2 |

## Verification
The top-byte check assumes that BC was loaded through a 24-bit write before any byte write to B or C. Until then the top byte is unknown, and comparing it with its own past value proves nothing. The directed tests therefore always load a pair in full before they touch its bytes. The assertions also assume that the register codes on `wr_sel` follow the R2 map and that `exx` is low during the byte writes they inspect. Every task drives only those codes, plus the deliberately unused codes 15 and 24. Inputs change only on the falling clock edge, so each strobe lasts exactly one rising edge.

// File: rtl/regfile24_pkg.sv
package regfile24_pkg;
    typedef enum logic [4:0] {
        RID_A   = 5'd0,  RID_F   = 5'd1,  RID_B   = 5'd2,  RID_C   = 5'd3,
        RID_D   = 5'd4,  RID_E   = 5'd5,  RID_H   = 5'd6,  RID_L   = 5'd7,
        RID_IXH = 5'd8,  RID_IXL = 5'd9,  RID_IYH = 5'd10, RID_IYL = 5'd11,
        RID_I   = 5'd12, RID_R   = 5'd13, RID_MB  = 5'd14,
        RID_BC  = 5'd16, RID_DE  = 5'd17, RID_HL  = 5'd18, RID_IX  = 5'd19,
        RID_IY  = 5'd20, RID_PC  = 5'd21, RID_SPL = 5'd22, RID_SPS = 5'd23
    } reg_id_e;

    typedef enum logic {
        BANK_MAIN = 1'b0,
        BANK_ALT  = 1'b1
    } bank_e;

    typedef enum logic [1:0] {
        FLG_ADL  = 2'd0,
        FLG_MADL = 2'd1,
        FLG_IEF1 = 2'd2,
        FLG_IEF2 = 2'd3
    } flag_id_e;

    localparam int NUM_BANKS = 2;
    localparam int NUM_PAIRS = 3;
    localparam int NUM_INDEX = 2;
endpackage

// File: rtl/regfile24_bank_fsm.sv
module regfile24_bank_fsm
    import regfile24_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  swap,
    output bank_e live
);
    bank_e state_q;
    bank_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BANK_MAIN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            BANK_MAIN: state_d = swap ? BANK_ALT  : BANK_MAIN;
            BANK_ALT:  state_d = swap ? BANK_MAIN : BANK_ALT;
        endcase
    end

    assign live = state_q;
endmodule

// File: rtl/regfile24_work.sv
module regfile24_work
    import regfile24_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WIDE_W = 3 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [4:0]        sel,
    input  logic [WIDE_W-1:0] wdata,
    input  logic              ex_af,
    input  logic              exx,
    input  logic [4:0]        rsel,
    output logic [WIDE_W-1:0] rval,
    output bank_e             af_live,
    output bank_e             gp_live,
    output logic [WIDE_W-1:0] bc_live
);
    logic [NUM_BANKS-1:0][BYTE_W-1:0]                a_all;
    logic [NUM_BANKS-1:0][BYTE_W-1:0]                f_all;
    logic [NUM_BANKS-1:0][NUM_PAIRS-1:0][WIDE_W-1:0] pr_all;

    regfile24_bank_fsm u_af_fsm (.clk(clk), .rst_n(rst_n), .swap(ex_af), .live(af_live));
    regfile24_bank_fsm u_gp_fsm (.clk(clk), .rst_n(rst_n), .swap(exx),   .live(gp_live));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BYTE_W-1:0] a_q;
        logic [BYTE_W-1:0] f_q;
        logic af_sel;
        logic gp_sel;
        assign af_sel = we && (af_live == bank_e'(b));
        assign gp_sel = we && (gp_live == bank_e'(b));

        // working registers carry no reset on purpose
        always_ff @(posedge clk) begin
            if (af_sel && sel == RID_A) a_q <= wdata[BYTE_W-1:0];
            if (af_sel && sel == RID_F) f_q <= wdata[BYTE_W-1:0];
        end
        assign a_all[b] = a_q;
        assign f_all[b] = f_q;

        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            localparam logic [4:0] ID_HI   = 5'(RID_B) + 5'(2 * p);
            localparam logic [4:0] ID_LO   = 5'(RID_C) + 5'(2 * p);
            localparam logic [4:0] ID_WIDE = 5'(RID_BC) + 5'(p);
            logic [WIDE_W-1:0] pr_q;
            always_ff @(posedge clk) begin
                if (gp_sel) begin
                    if (sel == ID_WIDE) begin
                        pr_q <= wdata;
                    end else if (sel == ID_HI) begin
                        pr_q <= {pr_q[WIDE_W-1:2*BYTE_W], wdata[BYTE_W-1:0], pr_q[BYTE_W-1:0]};
                    end else if (sel == ID_LO) begin
                        pr_q <= {pr_q[WIDE_W-1:BYTE_W], wdata[BYTE_W-1:0]};
                    end
                end
            end
            assign pr_all[b][p] = pr_q;
        end
    end

    logic [BYTE_W-1:0]                a_act;
    logic [BYTE_W-1:0]                f_act;
    logic [NUM_PAIRS-1:0][WIDE_W-1:0] pr_act;
    assign a_act   = a_all[af_live];
    assign f_act   = f_all[af_live];
    assign pr_act  = pr_all[gp_live];
    assign bc_live = pr_act[0];

    always_comb begin
        rval = '0;
        if (rsel == RID_A) rval = WIDE_W'(a_act);
        if (rsel == RID_F) rval = WIDE_W'(f_act);
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (rsel == 5'(RID_B) + 5'(2 * p))  rval = WIDE_W'(pr_act[p][2*BYTE_W-1:BYTE_W]);
            if (rsel == 5'(RID_C) + 5'(2 * p))  rval = WIDE_W'(pr_act[p][BYTE_W-1:0]);
            if (rsel == 5'(RID_BC) + 5'(p))     rval = pr_act[p];
        end
    end
endmodule

// File: rtl/regfile24_ctrl.sv
module regfile24_ctrl
    import regfile24_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WIDE_W = 3 * BYTE_W,
    localparam int SPS_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [4:0]        sel,
    input  logic [WIDE_W-1:0] wdata,
    input  logic              flag_we,
    input  logic [1:0]        flag_sel,
    input  logic              flag_val,
    input  logic [4:0]        rsel,
    output logic [WIDE_W-1:0] rval,
    output logic [3:0]        flags,
    output logic [BYTE_W-1:0] mbase,
    output logic [WIDE_W-1:0] pc
);
    logic [NUM_INDEX-1:0][WIDE_W-1:0] idx_all;
    logic [BYTE_W-1:0] i_q, r_q, mb_q;
    logic [WIDE_W-1:0] pc_q, spl_q;
    logic [SPS_W-1:0]  sps_q;
    logic [3:0]        flg_q;

    for (genvar k = 0; k < NUM_INDEX; k++) begin : g_index
        localparam logic [4:0] ID_HI   = 5'(RID_IXH) + 5'(2 * k);
        localparam logic [4:0] ID_LO   = 5'(RID_IXL) + 5'(2 * k);
        localparam logic [4:0] ID_WIDE = 5'(RID_IX) + 5'(k);
        logic [WIDE_W-1:0] ix_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ix_q <= '0;
            end else if (we) begin
                if (sel == ID_WIDE) begin
                    ix_q <= wdata;
                end else if (sel == ID_HI) begin
                    ix_q <= {ix_q[WIDE_W-1:2*BYTE_W], wdata[BYTE_W-1:0], ix_q[BYTE_W-1:0]};
                end else if (sel == ID_LO) begin
                    ix_q <= {ix_q[WIDE_W-1:BYTE_W], wdata[BYTE_W-1:0]};
                end
            end
        end
        assign idx_all[k] = ix_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q   <= '0;
            r_q   <= '0;
            mb_q  <= '0;
            pc_q  <= '0;
            spl_q <= '0;
            sps_q <= '0;
            flg_q <= '0;
        end else begin
            if (we) begin
                case (sel)
                    RID_I:   i_q   <= wdata[BYTE_W-1:0];
                    RID_R:   r_q   <= wdata[BYTE_W-1:0];
                    RID_MB:  if (flg_q[FLG_ADL]) mb_q <= wdata[BYTE_W-1:0];
                    RID_PC:  pc_q  <= wdata;
                    RID_SPL: spl_q <= wdata;
                    RID_SPS: sps_q <= wdata[SPS_W-1:0];
                    default: ;
                endcase
            end
            if (flag_we) flg_q[flag_sel] <= flag_val;
        end
    end

    always_comb begin
        rval = '0;
        case (sel_e(rsel))
            RID_I:   rval = WIDE_W'(i_q);
            RID_R:   rval = WIDE_W'(r_q);
            RID_MB:  rval = WIDE_W'(mb_q);
            RID_PC:  rval = pc_q;
            RID_SPL: rval = spl_q;
            RID_SPS: rval = WIDE_W'(sps_q);
            default: ;
        endcase
        for (int k = 0; k < NUM_INDEX; k++) begin
            if (rsel == 5'(RID_IXH) + 5'(2 * k)) rval = WIDE_W'(idx_all[k][2*BYTE_W-1:BYTE_W]);
            if (rsel == 5'(RID_IXL) + 5'(2 * k)) rval = WIDE_W'(idx_all[k][BYTE_W-1:0]);
            if (rsel == 5'(RID_IX) + 5'(k))      rval = idx_all[k];
        end
    end

    function automatic reg_id_e sel_e(input logic [4:0] v);
        return reg_id_e'(v);
    endfunction

    assign flags = flg_q;
    assign mbase = mb_q;
    assign pc    = pc_q;
endmodule

// File: rtl/regfile24.sv
module regfile24
    import regfile24_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [4:0]            wr_sel,
    input  logic [3*BYTE_W-1:0]   wr_data,
    input  logic                  ex_af,
    input  logic                  exx,
    input  logic                  flag_we,
    input  logic [1:0]            flag_sel,
    input  logic                  flag_val,
    input  logic [4:0]            rd_sel,
    output logic [3*BYTE_W-1:0]   rd_data,
    output logic                  adl,
    output logic                  madl,
    output logic                  ief1,
    output logic                  ief2
);
    localparam int WIDE_W = 3 * BYTE_W;

    logic [WIDE_W-1:0] work_rval;
    logic [WIDE_W-1:0] ctrl_rval;
    logic [WIDE_W-1:0] bc_live;
    logic [WIDE_W-1:0] pc_q;
    logic [BYTE_W-1:0] mbase_q;
    logic [3:0]        flags;
    bank_e             af_live;
    bank_e             gp_live;

    regfile24_work #(.BYTE_W(BYTE_W)) u_work (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .sel(wr_sel), .wdata(wr_data),
        .ex_af(ex_af), .exx(exx), .rsel(rd_sel), .rval(work_rval),
        .af_live(af_live), .gp_live(gp_live), .bc_live(bc_live)
    );

    regfile24_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .sel(wr_sel), .wdata(wr_data),
        .flag_we(flag_we), .flag_sel(flag_sel), .flag_val(flag_val),
        .rsel(rd_sel), .rval(ctrl_rval), .flags(flags), .mbase(mbase_q), .pc(pc_q)
    );

    // each code belongs to exactly one side; the other side returns zero
    assign rd_data = work_rval | ctrl_rval;
    assign adl  = flags[FLG_ADL];
    assign madl = flags[FLG_MADL];
    assign ief1 = flags[FLG_IEF1];
    assign ief2 = flags[FLG_IEF2];
endmodule

// File: rtl/regfile24_chk.sv
module regfile24_chk
    import regfile24_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WIDE_W = 3 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [4:0]        wr_sel,
    input logic [WIDE_W-1:0] wr_data,
    input logic              ex_af,
    input logic              exx,
    input logic              flag_we,
    input logic              adl,
    input logic              madl,
    input logic              ief1,
    input logic              ief2,
    input logic [BYTE_W-1:0] mbase,
    input bank_e             af_live,
    input bank_e             gp_live,
    input logic [WIDE_W-1:0] bc_live,
    input logic [WIDE_W-1:0] pc
);
    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == RID_PC) |=> $stable(pc));

    p_af_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ex_af |=> (af_live != $past(af_live)));

    p_af_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_af |=> $stable(af_live));

    p_gp_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exx |=> (gp_live != $past(gp_live)));

    p_gp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !exx |=> $stable(gp_live));

    p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exx && (wr_sel == RID_B || wr_sel == RID_C))
        |=> (bc_live[WIDE_W-1:2*BYTE_W] == $past(bc_live[WIDE_W-1:2*BYTE_W])));

    p_mbase_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == RID_MB && !adl) |=> $stable(mbase));

    p_mbase_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == RID_MB && adl) |=> (mbase == $past(wr_data[BYTE_W-1:0])));

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable({adl, madl, ief1, ief2}));
endmodule

bind regfile24 regfile24_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ex_af(ex_af), .exx(exx), .flag_we(flag_we),
    .adl(adl), .madl(madl), .ief1(ief1), .ief2(ief2),
    .mbase(mbase_q), .af_live(af_live), .gp_live(gp_live), .bc_live(bc_live), .pc(pc_q)
);

// File: tb/tb_regfile24.sv
module tb_regfile24;
    localparam logic [4:0] C_A = 0, C_F = 1, C_B = 2, C_C = 3, C_H = 6, C_L = 7,
        C_IXH = 8, C_IXL = 9, C_IYH = 10, C_IYL = 11, C_I = 12, C_R = 13, C_MB = 14,
        C_BC = 16, C_DE = 17, C_HL = 18, C_IX = 19, C_IY = 20, C_PC = 21, C_SPL = 22, C_SPS = 23;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, ex_af = 0, exx = 0, flag_we = 0, flag_val = 0;
    logic [4:0]  wr_sel = 0, rd_sel = 0;
    logic [1:0]  flag_sel = 0;
    logic [23:0] wr_data = 0, rd_data;
    logic        adl, madl, ief1, ief2;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    regfile24 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ex_af(ex_af), .exx(exx), .flag_we(flag_we), .flag_sel(flag_sel), .flag_val(flag_val),
        .rd_sel(rd_sel), .rd_data(rd_data), .adl(adl), .madl(madl), .ief1(ief1), .ief2(ief2)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_rd(input string req, input logic [4:0] s, input logic [23:0] exp);
        rd_sel = s;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic cyc(input logic we, input logic [4:0] s, input logic [23:0] d,
                       input logic xa, input logic xx,
                       input logic fwe, input logic [1:0] fs, input logic fv);
        @(negedge clk);
        wr_en = we; wr_sel = s; wr_data = d; ex_af = xa; exx = xx;
        flag_we = fwe; flag_sel = fs; flag_val = fv;
        @(negedge clk);
        wr_en = 0; ex_af = 0; exx = 0; flag_we = 0;
    endtask

    task automatic wr(input logic [4:0] s, input logic [23:0] d);
        cyc(1, s, d, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset_r1;
        check_rd("R1 I", C_I, 0);
        check_rd("R1 R", C_R, 0);
        check_rd("R1 MBASE", C_MB, 0);
        check_rd("R1 IX", C_IX, 0);
        check_rd("R1 IY", C_IY, 0);
        check_rd("R1 IXH", C_IXH, 0);
        check_rd("R1 IYL", C_IYL, 0);
        check_rd("R1 PC", C_PC, 0);
        check_rd("R1 SPL", C_SPL, 0);
        check_rd("R1 SPS", C_SPS, 0);
        check("R1 flags", {20'h0, adl, madl, ief1, ief2}, 0);
    endtask

    task automatic t_access_r2_r5;
        wr(C_BC, 24'h123456);
        check_rd("R2 BC wide", C_BC, 24'h123456);
        check_rd("R2 B byte", C_B, 24'h000034);
        check_rd("R2 C byte", C_C, 24'h000056);
        wr(C_B, 24'hFFFFAB);
        check_rd("R5 B write keeps upper", C_BC, 24'h12AB56);
        wr(C_C, 24'h0000CD);
        check_rd("R5 C write keeps upper", C_BC, 24'h12ABCD);
        wr(C_HL, 24'h0F0E0D);
        wr(C_L, 24'h000099);
        check_rd("R5 L write", C_HL, 24'h0F0E99);
        wr(C_IX, 24'hA1B2C3);
        wr(C_IXL, 24'h000077);
        check_rd("R5 IXL write", C_IX, 24'hA1B277);
        wr(C_IY, 24'h102030);
        wr(C_IYH, 24'h0000EE);
        check_rd("R5 IYH write", C_IY, 24'h10EE30);
        wr(C_PC, 24'hFEDCBA);
        check_rd("R2 PC", C_PC, 24'hFEDCBA);
        wr(C_SPS, 24'h9ABCDE);
        check_rd("R2 SPS 16-bit", C_SPS, 24'h00BCDE);
        wr(C_SPL, 24'h654321);
        check_rd("R2 SPL", C_SPL, 24'h654321);
    endtask

    task automatic t_exaf_r3;
        wr(C_A, 24'h11);
        wr(C_F, 24'h22);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        wr(C_A, 24'h33);
        wr(C_F, 24'h44);
        check_rd("R3 alt A", C_A, 24'h33);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        check_rd("R3 main A back", C_A, 24'h11);
        check_rd("R3 main F back", C_F, 24'h22);
        cyc(1, C_A, 24'h55, 1, 0, 0, 0, 0);
        check_rd("R3 swap+write shows alt", C_A, 24'h33);
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        check_rd("R3 write landed in main", C_A, 24'h55);
    endtask

    task automatic t_exx_r4;
        wr(C_BC, 24'h010203);
        wr(C_HL, 24'h0A0B0C);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        wr(C_BC, 24'hF1F2F3);
        check_rd("R4 alt BC", C_BC, 24'hF1F2F3);
        cyc(1, C_DE, 24'h777777, 0, 1, 0, 0, 0);
        check_rd("R4 main BC back", C_BC, 24'h010203);
        check_rd("R4 main HL back", C_HL, 24'h0A0B0C);
        check_rd("R4 main B", C_B, 24'h000002);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        check_rd("R4 same-cycle write in alt", C_DE, 24'h777777);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        check_rd("R4 back in main", C_BC, 24'h010203);
    endtask

    task automatic t_mbase_r6;
        wr(C_MB, 24'h5A);
        check_rd("R6 write ignored with ADL=0", C_MB, 24'h0);
        cyc(0, 0, 0, 0, 0, 1, 2'd0, 1);
        wr(C_MB, 24'h5A);
        check_rd("R6 write taken with ADL=1", C_MB, 24'h5A);
        cyc(1, C_MB, 24'h77, 0, 0, 1, 2'd0, 0);
        check_rd("R6 old ADL=1 governs", C_MB, 24'h77);
        cyc(1, C_MB, 24'h99, 0, 0, 1, 2'd0, 1);
        check_rd("R6 old ADL=0 governs", C_MB, 24'h77);
    endtask

    task automatic t_rdw_r7;
        wr(C_I, 24'h3C);
        @(negedge clk);
        wr_en = 1; wr_sel = C_I; wr_data = 24'hC3; rd_sel = C_I;
        #1;
        check("R7 old value same cycle", rd_data, 24'h3C);
        @(negedge clk);
        wr_en = 0;
        #1;
        check("R7 new value next cycle", rd_data, 24'hC3);
    endtask

    task automatic t_flags_r8;
        cyc(0, 0, 0, 0, 0, 1, 2'd1, 1);
        check("R8 MADL set", {20'h0, adl, madl, ief1, ief2}, 24'h4 | 24'h8);
        cyc(0, 0, 0, 0, 0, 1, 2'd2, 1);
        cyc(0, 0, 0, 0, 0, 1, 2'd3, 1);
        check("R8 IEF1 IEF2 set", {20'h0, adl, madl, ief1, ief2}, 24'hF);
        cyc(0, 0, 0, 0, 0, 1, 2'd2, 0);
        check("R8 IEF1 cleared alone", {20'h0, adl, madl, ief1, ief2}, 24'hD);
    endtask

    task automatic t_unused_r9;
        wr(5'd15, 24'hFFFFFF);
        wr(5'd24, 24'hFFFFFF);
        check_rd("R9 code 15 reads 0", 5'd15, 0);
        check_rd("R9 code 24 reads 0", 5'd24, 0);
        check_rd("R9 code 31 reads 0", 5'd31, 0);
        check_rd("R9 I untouched", C_I, 24'hC3);
        check_rd("R9 MBASE untouched", C_MB, 24'h77);
        check_rd("R9 A untouched", C_A, 24'h55);
        check_rd("R9 BC untouched", C_BC, 24'h010203);
    endtask

    task automatic t_keep_r10;
        wr(C_A, 24'h6C);
        wr(C_BC, 24'h445566);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check_rd("R10 A survives reset", C_A, 24'h6C);
        check_rd("R10 BC survives reset", C_BC, 24'h445566);
        check_rd("R1 PC cleared again", C_PC, 0);
        check_rd("R1 IX cleared again", C_IX, 0);
        check("R1 flags cleared again", {20'h0, adl, madl, ief1, ief2}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_r1();
        @(negedge clk);
        rst_n = 1;
        t_reset_r1();
        t_access_r2_r5();
        t_exaf_r3();
        t_exx_r4();
        t_mbase_r6();
        t_rdw_r7();
        t_flags_r8();
        t_unused_r9();
        t_keep_r10();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule